// File: doc/BRIEF.md
# Generalized Reverse/Combine Unit

This block is a bit-permutation unit for a processor datapath. An XLEN-bit operand passes through log2(XLEN) butterfly stages. Stage k pairs bit i with bit i XOR 2^k, and every output bit is an AND-OR of the bit itself and that partner. Each term is gated by its own enable.

The enables come from two 2-entry lookup tables held in a 6-bit function code. Both tables are indexed by the stage's shift-control bit. The same four table bits serve every stage. Two further code bits invert the operand on entry and the result on exit. One network with the depth of a plain reverse network therefore computes generalized reverse (grev), generalized OR-combine (gorc) and generalized AND-combine (gandc). A fixed-function input forces plain grev whatever the code says, which serves the immediate-shift form (bit reversal, byte reversal).

The unit sits behind a one-entry valid/ready output register. A beat is accepted when `in_valid` and `in_ready` are both high at a clock edge. Its result appears on `out_data` with `out_valid` on the following cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and `in_ready` is low. The unit accepts a new beat in the same cycle the held result is taken, so full throughput is kept.

Top module: `grc_unit`

## Requirements
- R1: Function code layout: bits [1:0] form the self table, bits [3:2] the partner table, bit 4 inverts the operand before the first stage, and bit 5 inverts the result after the last stage. In stage k (k = 0 first, k = log2(XLEN)-1 last), out[i] = (x[i] & self[s]) | (x[i ^ 2^k] & partner[s]), where s = shamt[k].
- R2: Code 0x09 (grev) gives out[i] = in[i ^ shamt] for every i.
- R3: Code 0x0B (gorc) gives out[i] = OR of in[i ^ m] over every m whose set bits are a subset of shamt. Every 1 bit of the operand stays 1.
- R4: With shamt = 0 and code 0x09 or 0x0B, the result equals the operand.
- R5: Code 0x3B (gandc) gives NOT(gorc(NOT in)). Every 0 bit of the operand stays 0.
- R6: Bit 4 alone complements the operand ahead of the network, and bit 5 alone complements the result after it. With code 0x19 the result equals grev(NOT in), and with code 0x29 it equals NOT grev(in).
- R7: With `in_fixed` high, the result is grev(in, shamt) whatever `in_func` holds.
- R8: grev with shamt all ones reverses the bit order. grev with shamt = XLEN-8 reverses the byte order.
- R9: A beat accepted at one edge is presented on `out_valid`/`out_data` after that edge. While `out_valid` is high and `out_ready` is low, `out_data` holds and `in_ready` is low.
- R10: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Unit can take a beat |
| in_data | input | XLEN | Operand |
| in_shamt | input | log2(XLEN) | Shift control, one bit per stage |
| in_func | input | 6 | Function code (tables and inversions) |
| in_fixed | input | 1 | Force plain grev |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | XLEN | Result |

## Verification
Every cycle the assertions check the handshake. They check that a held result stays stable under back-pressure, that an accepted beat yields a valid output, and that reset empties the register. On the combinational side they check, for every evaluated operand, that shamt = 0 passes the operand through, that gorc keeps all ones, and that gandc keeps all zeros. The exact permutations need the bench's reference models. These are grev against the index-XOR definition, gorc against the subset OR, arbitrary table codes against the stage formula, and the bit and byte reversals.

// File: rtl/grc_pkg.sv
package grc_pkg;

  typedef struct packed {
    logic       inv_out;      // bit 5
    logic       inv_in;       // bit 4
    logic [1:0] partner_lut;  // bits 3:2
    logic [1:0] self_lut;     // bits 1:0
  } grc_func_t;

  localparam logic [5:0] FN_GREV  = 6'h09;
  localparam logic [5:0] FN_GORC  = 6'h0B;
  localparam logic [5:0] FN_GANDC = 6'h3B;

endpackage

// File: rtl/grc_stage.sv
module grc_stage #(
  parameter int XLEN = 32,
  parameter int DIST = 1
) (
  input  logic [XLEN-1:0] x,
  input  logic            sh_bit,
  input  logic [1:0]      self_lut,
  input  logic [1:0]      partner_lut,
  output logic [XLEN-1:0] y
);
  logic self_en, partner_en;

  assign self_en    = self_lut[sh_bit];
  assign partner_en = partner_lut[sh_bit];

  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    localparam int PEER = i ^ DIST;
    assign y[i] = (x[i] & self_en) | (x[PEER] & partner_en);
  end
endmodule

// File: rtl/grc_core.sv
module grc_core
  import grc_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] opnd,
  input  logic [SHW-1:0]  shamt,
  input  logic [5:0]      func,
  input  logic            fixed,
  output logic [XLEN-1:0] res
);
  grc_func_t fn;
  logic [XLEN-1:0] chain [SHW+1];

  assign fn       = grc_func_t'(fixed ? FN_GREV : func);
  assign chain[0] = opnd ^ {XLEN{fn.inv_in}};

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    grc_stage #(.XLEN(XLEN), .DIST(1 << k)) u_stage (
      .x          (chain[k]),
      .sh_bit     (shamt[k]),
      .self_lut   (fn.self_lut),
      .partner_lut(fn.partner_lut),
      .y          (chain[k+1])
    );
  end

  assign res = chain[SHW] ^ {XLEN{fn.inv_out}};

  always_comb begin
    if (!$isunknown({opnd, shamt, func, fixed})) begin
      if (shamt == '0 && (fixed || func == FN_GREV || func == FN_GORC))
        assert_zero_shift_identity_R4: assert (res == opnd);
      if (!fixed && func == FN_GORC)
        assert_gorc_keeps_ones_R3: assert ((res & opnd) == opnd);
      if (!fixed && func == FN_GANDC)
        assert_gandc_keeps_zeros_R5: assert ((res & ~opnd) == '0);
    end
  end
endmodule

// File: rtl/grc_unit.sv
module grc_unit #(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [XLEN-1:0] in_data,
  input  logic [SHW-1:0]  in_shamt,
  input  logic [5:0]      in_func,
  input  logic            in_fixed,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_data
);
  logic [XLEN-1:0] core_res;
  logic            take;

  grc_core #(.XLEN(XLEN)) u_core (
    .opnd (in_data),
    .shamt(in_shamt),
    .func (in_func),
    .fixed(in_fixed),
    .res  (core_res)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= core_res;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  assert_accept_gives_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  assert_stall_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  assert_reset_empties_R10: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/grc_unit_bench.sv
module grc_unit_bench;
  localparam int XLEN = 32;
  localparam int SHW  = $clog2(XLEN);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [XLEN-1:0] in_data = '0;
  logic [SHW-1:0]  in_shamt = '0;
  logic [5:0]      in_func = '0;
  logic            in_fixed = 1'b0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [XLEN-1:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  grc_unit #(.XLEN(XLEN)) u_grc_unit (.*);

  function automatic logic [XLEN-1:0] ref_grev(logic [XLEN-1:0] x, logic [SHW-1:0] s);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) r[i] = x[i ^ int'(s)];
    return r;
  endfunction

  function automatic logic [XLEN-1:0] ref_gorc(logic [XLEN-1:0] x, logic [SHW-1:0] s);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) begin
      r[i] = 1'b0;
      for (int m = 0; m < XLEN; m++)
        if ((m & ~int'(s)) == 0) r[i] = r[i] | x[i ^ m];
    end
    return r;
  endfunction

  function automatic logic [XLEN-1:0] ref_stages(logic [XLEN-1:0] x, logic [SHW-1:0] s,
                                                 logic [5:0] f);
    logic [XLEN-1:0] a, b;
    a = x ^ {XLEN{f[4]}};
    for (int k = 0; k < SHW; k++) begin
      for (int i = 0; i < XLEN; i++)
        b[i] = (a[i] & f[int'(s[k])]) | (a[i ^ (1 << k)] & f[2 + int'(s[k])]);
      a = b;
    end
    return a ^ {XLEN{f[5]}};
  endfunction

  function automatic logic [XLEN-1:0] bit_rev(logic [XLEN-1:0] x);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) r[i] = x[XLEN-1-i];
    return r;
  endfunction

  function automatic logic [XLEN-1:0] byte_rev(logic [XLEN-1:0] x);
    logic [XLEN-1:0] r;
    for (int b = 0; b < XLEN/8; b++) r[b*8 +: 8] = x[(XLEN/8-1-b)*8 +: 8];
    return r;
  endfunction

  task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Apply one beat with out_ready high; sample result one cycle later.
  task automatic run(logic [XLEN-1:0] d, logic [SHW-1:0] s, logic [5:0] f, logic fx,
                     output logic [XLEN-1:0] r);
    @(negedge clk);
    in_data = d; in_shamt = s; in_func = f; in_fixed = fx; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    r = out_data;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_bit("R10 out_valid in reset", out_valid, 1'b0);
    check_bit("R10 in_ready in reset", in_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R10 out_valid after reset", out_valid, 1'b0);
  endtask

  task automatic t_grev();
    logic [XLEN-1:0] r;
    logic [XLEN-1:0] d;
    for (int s = 0; s < XLEN; s += 5) begin
      d = 32'hA5C3_0F17 ^ (s * 32'h0101_3B1D);
      run(d, SHW'(s), 6'h09, 1'b0, r);
      check("R2 grev", r, ref_grev(d, SHW'(s)));
    end
  endtask

  task automatic t_gorc();
    logic [XLEN-1:0] r;
    logic [XLEN-1:0] d;
    for (int s = 1; s < XLEN; s += 6) begin
      d = 32'h0001_0200 << (s % 7);
      run(d, SHW'(s), 6'h0B, 1'b0, r);
      check("R3 gorc", r, ref_gorc(d, SHW'(s)));
    end
  endtask

  task automatic t_identity();
    logic [XLEN-1:0] r;
    run(32'hDEAD_BEEF, '0, 6'h09, 1'b0, r);
    check("R4 grev shamt 0", r, 32'hDEAD_BEEF);
    run(32'h1234_8001, '0, 6'h0B, 1'b0, r);
    check("R4 gorc shamt 0", r, 32'h1234_8001);
  endtask

  task automatic t_gandc();
    logic [XLEN-1:0] r;
    logic [XLEN-1:0] d;
    for (int s = 2; s < XLEN; s += 9) begin
      d = ~(32'h0100_0008 << (s % 5));
      run(d, SHW'(s), 6'h3B, 1'b0, r);
      check("R5 gandc", r, ~ref_gorc(~d, SHW'(s)));
    end
  endtask

  task automatic t_inversion();
    logic [XLEN-1:0] r;
    run(32'h0F0F_1234, 5'd3, 6'h19, 1'b0, r);
    check("R6 input invert", r, ref_grev(~32'h0F0F_1234, 5'd3));
    run(32'h0F0F_1234, 5'd3, 6'h29, 1'b0, r);
    check("R6 output invert", r, ~ref_grev(32'h0F0F_1234, 5'd3));
  endtask

  task automatic t_tables();
    logic [XLEN-1:0] r;
    logic [XLEN-1:0] d;
    for (int f = 0; f < 64; f += 7) begin
      d = 32'h9E37_79B9 * (f + 1);
      run(d, SHW'(f * 3), 6'(f), 1'b0, r);
      check("R1 table code", r, ref_stages(d, SHW'(f * 3), 6'(f)));
    end
  endtask

  task automatic t_fixed();
    logic [XLEN-1:0] r;
    run(32'hCAFE_0123, 5'd7, 6'h3B, 1'b1, r);
    check("R7 fixed over gandc code", r, ref_grev(32'hCAFE_0123, 5'd7));
    run(32'hCAFE_0123, 5'd12, 6'h00, 1'b1, r);
    check("R7 fixed over zero code", r, ref_grev(32'hCAFE_0123, 5'd12));
  endtask

  task automatic t_reversal();
    logic [XLEN-1:0] r;
    run(32'h1234_5678, '1, 6'h09, 1'b0, r);
    check("R8 bit reverse", r, bit_rev(32'h1234_5678));
    run(32'h1234_5678, SHW'(XLEN - 8), 6'h09, 1'b0, r);
    check("R8 byte reverse", r, byte_rev(32'h1234_5678));
    run(32'h8000_00F1, '1, 6'h00, 1'b1, r);
    check("R8 fixed bit reverse", r, bit_rev(32'h8000_00F1));
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    in_data = 32'h0000_00FF; in_shamt = '0; in_func = 6'h09; in_fixed = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    check_bit("R9 valid after accept", out_valid, 1'b1);
    check_bit("R9 in_ready low when stalled", in_ready, 1'b0);
    in_data = 32'hFF00_0000;
    repeat (3) @(negedge clk);
    check("R9 data held under stall", out_data, 32'h0000_00FF);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 next beat after release", out_data, 32'hFF00_0000);
    check_bit("R9 valid after release", out_valid, 1'b1);
    @(negedge clk);
    check_bit("R9 empty after drain", out_valid, 1'b0);
  endtask

  initial begin
    t_reset();
    t_identity();
    t_grev();
    t_gorc();
    t_gandc();
    t_inversion();
    t_tables();
    t_fixed();
    t_reversal();
    t_backpressure();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule